// File: doc/BRIEF.md
# Four-Floor Lift Controller

This block is a synchronous state machine that moves a lift car between four landings (ground, 1, 2 and 3) and runs its door. A fine-grained 8-bit position reading is turned into one of seven position zones: a zone for each landing and a zone for each gap between neighbouring landings. Call buttons on the landings and destination buttons in the car are sampled together. When the controller is idle, the lowest landing asked for is latched as the single request to serve.

The controller then runs the motor towards that landing. It drives up when the car is below the landing and down otherwise. It stops once the car's zone matches the landing, and it opens the door for a fixed dwell before closing it and dropping the request. An overload input keeps the door open and the car parked, and it sounds a beeper for as long as it lasts. A one-hot display shows the last landing the car passed or stood at.

Top module: `lift_ctrl`

## Requirements
- R1: After synchronous reset, door_open, motor_go and beep are 0, floor_disp is 4'b0001 (ground) and no request is pending.
- R2: Landing k is detected when car_pos lies within ±4 of k*64. Any other value is the gap zone between the two nearest landings. A reading above the top window counts as the top landing. floor_disp bit k set alone means landing k was the last landing zone seen, and this value holds while the car is in a gap.
- R3: While idle with no request pending, the lowest-numbered set bit of (call_out | call_in), where bit k means landing k, is latched as the request. Other buttons pressed in the same cycle are not served.
- R4: While the motor runs, dir_up is 1 if the car's zone is below the requested landing and 0 otherwise. The motor stops once the car's zone equals the requested landing.
- R5: door_open is 1 only while motor_go is 0, and it rises only when the car's zone equals the requested landing.
- R6: Without overload, the door stays open for exactly 16 clock cycles and then closes. The request is then cleared, and the motor stays stopped until a new button press.
- R7: A request for the landing the car already stands at opens the door without running the motor.
- R8: While overload is 1 with the door open, the door stays open, the motor stays stopped and beep is 1. The dwell count is paused, so after release the door closes within the remaining part of the 16 cycles. beep is 0 whenever the door is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_out | input | 4 | Landing call buttons, bit k = landing k |
| call_in | input | 4 | Car destination buttons, bit k = landing k |
| car_pos | input | 8 | Fine car position reading |
| overload | input | 1 | Car weight over the limit |
| dir_up | output | 1 | Motor direction, 1 = up |
| motor_go | output | 1 | Motor run command, 1 = run |
| door_open | output | 1 | Door command, 1 = open |
| floor_disp | output | 4 | One-hot last landing reached |
| beep | output | 1 | Overload warning |

## Verification
Trips are made in both directions and over one and two landings. A downward run through two gaps shows whether the display holds the last landing while the car is between landings. Pressing two buttons together in one cycle, across both button vectors, separates a lowest-first choice from a highest-first one or from ignoring the car buttons. A call to the landing the car is already at, and an overload raised in the middle of a dwell, show whether the motor wrongly starts and whether the dwell count pauses rather than restarts or ends early.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_MOVE = 2'd1,
    CTL_DOOR = 2'd2
  } ctl_st_e;

  // Zone index: even = landing (index/2), odd = gap above landing (index-1)/2
  function automatic int zone_of(input int pos, input int pitch,
                                 input int win, input int n_land);
    int f;
    int ctr;
    int z;
    f = (pos + pitch / 2) / pitch;
    if (f > n_land - 1) f = n_land - 1;
    ctr = f * pitch;
    if ((pos >= ctr - win) && (pos <= ctr + win)) z = 2 * f;
    else if (pos < ctr) z = 2 * f - 1;
    else z = 2 * f + 1;
    if (z > 2 * (n_land - 1)) z = 2 * (n_land - 1);
    return z;
  endfunction

  // Index of the lowest set bit, 0 when none set
  function automatic int lowest_set(input logic [31:0] v, input int n);
    int idx;
    idx = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/lift_zone.sv
module lift_zone #(
  parameter int POS_W = 8,
  parameter int N_LAND = 4,
  parameter int PITCH = 64,
  parameter int WIN = 4,
  localparam int ZW = $clog2(2 * N_LAND - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [POS_W-1:0]  pos,
  output logic [ZW-1:0]     zone_q,
  output logic [N_LAND-1:0] last_land_q
);
  import lift_pkg::*;

  logic [ZW-1:0] zone_d;
  int zone_i;

  always_comb begin
    zone_i = zone_of(int'(pos), PITCH, WIN, N_LAND);
    zone_d = ZW'(zone_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_q      <= '0;
      last_land_q <= N_LAND'(1);
    end else begin
      zone_q <= zone_d;
      if (!zone_q[0]) last_land_q <= N_LAND'(1) << (zone_q >> 1);
    end
  end
endmodule

// File: rtl/lift_req.sv
module lift_req #(
  parameter int N_LAND = 4,
  localparam int FW = (N_LAND > 1) ? $clog2(N_LAND) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [N_LAND-1:0] buttons,
  input  logic              clear,
  output logic              valid_q,
  output logic [FW-1:0]     land_q
);
  import lift_pkg::*;

  logic [FW-1:0] pick;

  always_comb begin
    pick = FW'(lowest_set(32'(buttons), N_LAND));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      land_q  <= '0;
    end else if (clear) begin
      valid_q <= 1'b0;
    end else if (load_en && !valid_q && (|buttons)) begin
      valid_q <= 1'b1;
      land_q  <= pick;
    end
  end
endmodule

// File: rtl/lift_door.sv
module lift_door #(
  parameter int DWELL = 16,
  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic hold,
  output logic done
);
  logic [CW-1:0] cnt_q;

  assign done = active && !hold && (cnt_q == CW'(DWELL - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (!hold && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl #(
  parameter int POS_W = 8,
  parameter int N_LAND = 4,
  parameter int PITCH = 64,
  parameter int WIN = 4,
  parameter int DWELL = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LAND-1:0] call_out,
  input  logic [N_LAND-1:0] call_in,
  input  logic [POS_W-1:0]  car_pos,
  input  logic              overload,
  output logic              dir_up,
  output logic              motor_go,
  output logic              door_open,
  output logic [N_LAND-1:0] floor_disp,
  output logic              beep
);
  import lift_pkg::*;

  localparam int ZW = $clog2(2 * N_LAND - 1);
  localparam int FW = (N_LAND > 1) ? $clog2(N_LAND) : 1;

  ctl_st_e st_q, st_d;

  // Named internal events for the checker
  logic [ZW-1:0] cur_zone;
  logic [ZW-1:0] tgt_zone;
  logic          req_valid;
  logic [FW-1:0] req_land;
  logic          door_done;
  logic          at_target;

  lift_zone #(.POS_W(POS_W), .N_LAND(N_LAND), .PITCH(PITCH), .WIN(WIN)) u_zone (
    .clk(clk), .rst(rst), .pos(car_pos),
    .zone_q(cur_zone), .last_land_q(floor_disp)
  );

  lift_req #(.N_LAND(N_LAND)) u_req (
    .clk(clk), .rst(rst),
    .load_en(st_q == CTL_IDLE),
    .buttons(call_out | call_in),
    .clear(door_done),
    .valid_q(req_valid), .land_q(req_land)
  );

  lift_door #(.DWELL(DWELL)) u_door (
    .clk(clk), .rst(rst),
    .active(st_q == CTL_DOOR), .hold(overload),
    .done(door_done)
  );

  assign tgt_zone  = ZW'({req_land, 1'b0});
  assign at_target = (cur_zone == tgt_zone);

  always_comb begin
    st_d = st_q;
    case (st_q)
      CTL_IDLE: if (req_valid) st_d = at_target ? CTL_DOOR : CTL_MOVE;
      CTL_MOVE: if (at_target) st_d = CTL_DOOR;
      CTL_DOOR: if (door_done) st_d = CTL_IDLE;
      default:  st_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= CTL_IDLE;
    else     st_q <= st_d;
  end

  assign motor_go  = (st_q == CTL_MOVE);
  assign dir_up    = (cur_zone < tgt_zone);
  assign door_open = (st_q == CTL_DOOR);
  assign beep      = door_open && overload;
endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk #(
  parameter int ZW = 3,
  parameter int N_LAND = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              overload,
  input logic              motor_go,
  input logic              door_open,
  input logic              beep,
  input logic [N_LAND-1:0] floor_disp,
  input logic [ZW-1:0]     cur_zone,
  input logic [ZW-1:0]     tgt_zone,
  input logic              req_valid,
  input logic              door_done
);
  // R5
  door_parked_chk: assert property (@(posedge clk) disable iff (rst)
    door_open |-> !motor_go);

  // R5
  door_at_target_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(door_open) |-> (req_valid && cur_zone == tgt_zone));

  // R4
  run_has_request_chk: assert property (@(posedge clk) disable iff (rst)
    motor_go |-> req_valid);

  // R6
  dwell_end_chk: assert property (@(posedge clk) disable iff (rst)
    door_done |=> (!door_open && !req_valid));

  // R8
  overload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (door_open && overload) |=> door_open);

  // R8
  beep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    beep |-> (door_open && overload));

  // R2
  disp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(floor_disp) == 1);
endmodule

bind lift_ctrl lift_ctrl_chk #(.ZW(ZW), .N_LAND(N_LAND)) u_chk (
  .clk(clk), .rst(rst), .overload(overload), .motor_go(motor_go),
  .door_open(door_open), .beep(beep), .floor_disp(floor_disp),
  .cur_zone(cur_zone), .tgt_zone(tgt_zone), .req_valid(req_valid),
  .door_done(door_done)
);

// File: tb/lift_ctrl_tb.sv
`timescale 1ns/1ps
module lift_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] call_out = '0;
  logic [3:0] call_in = '0;
  logic [7:0] pos = '0;
  logic       overload = 1'b0;
  logic       dir_up, motor_go, door_open, beep;
  logic [3:0] floor_disp;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lift_ctrl u_dut (
    .clk(clk), .rst(rst), .call_out(call_out), .call_in(call_in),
    .car_pos(pos), .overload(overload), .dir_up(dir_up),
    .motor_go(motor_go), .door_open(door_open),
    .floor_disp(floor_disp), .beep(beep)
  );

  // Car model: one count per clock while the motor runs
  always @(posedge clk) begin
    if (rst) pos <= '0;
    else if (motor_go) pos <= dir_up ? pos + 8'd1 : pos - 8'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_open(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (door_open) break;
      @(negedge clk);
    end
  endtask

  task automatic press(input logic [3:0] o, input logic [3:0] c);
    call_out = o; call_in = c;
    @(negedge clk);
    call_out = '0; call_in = '0;
  endtask

  function automatic int dwell_len();
    return 0;
  endfunction

  task automatic wait_closed(output int len);
    len = 0;
    while (door_open && len < 200) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(door_open == 0 && motor_go == 0 && beep == 0, "R1 door/go/beep", {door_open, motor_go, beep}, 0);
    check(floor_disp == 4'b0001, "R1 display", floor_disp, 1);
  endtask

  task automatic t_up_two();
    int len;
    press(4'b0100, 4'b0000);
    for (int i = 0; i < 10 && !motor_go; i++) @(negedge clk);
    check(motor_go && dir_up, "R4 run up", {motor_go, dir_up}, 3);
    wait_open(400);
    check(door_open, "R5 door opens at 2", door_open, 1);
    check(pos >= 124 && pos <= 132, "R4 stop window 2", pos, 128);
    check(floor_disp == 4'b0100, "R2 display at 2", floor_disp, 4);
    check(!motor_go, "R5 parked", motor_go, 0);
    wait_closed(len);
    check(len == 16, "R6 dwell length", len, 16);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(!motor_go && !door_open, "R6 idle after dwell", {motor_go, door_open}, 0);
  endtask

  task automatic t_down_gaps();
    int len;
    press(4'b0000, 4'b0001);
    for (int i = 0; i < 300 && pos > 96; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(floor_disp == 4'b0100, "R2 gap 1-2 holds 2", floor_disp, 4);
    check(motor_go && !dir_up, "R4 run down", {motor_go, dir_up}, 2);
    for (int i = 0; i < 300 && pos > 32; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    check(floor_disp == 4'b0010, "R2 gap 0-1 holds 1", floor_disp, 2);
    wait_open(300);
    check(door_open && pos <= 4, "R4 stop at ground", pos, 0);
    check(floor_disp == 4'b0001, "R2 display at 0", floor_disp, 1);
    wait_closed(len);
  endtask

  task automatic t_lowest();
    int len;
    press(4'b1000, 4'b0010);
    wait_open(300);
    check(door_open && pos >= 60 && pos <= 68, "R3 lowest served", pos, 64);
    check(floor_disp == 4'b0010, "R3 display at 1", floor_disp, 2);
    wait_closed(len);
    for (int i = 0; i < 5; i++) @(negedge clk);
    check(!motor_go && !door_open, "R3 other button dropped", {motor_go, door_open}, 0);
  endtask

  task automatic t_same_floor();
    int len;
    int moved;
    logic [7:0] p0;
    p0 = pos;
    moved = 0;
    call_in = 4'b0010;
    @(negedge clk);
    call_in = '0;
    for (int i = 0; i < 8 && !door_open; i++) begin
      if (motor_go) moved++;
      @(negedge clk);
    end
    check(door_open, "R7 door opens in place", door_open, 1);
    check(moved == 0 && pos == p0, "R7 no motion", int'(pos), int'(p0));
    wait_closed(len);
  endtask

  task automatic t_overload();
    int len;
    int bad;
    press(4'b0010, 4'b0000);
    wait_open(10);
    for (int i = 0; i < 3; i++) @(negedge clk);
    overload = 1'b1;
    @(negedge clk);
    check(beep == 1, "R8 beep on", beep, 1);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (!door_open || motor_go) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 held open and parked", bad, 0);
    overload = 1'b0;
    #0.1;
    check(beep == 0, "R8 beep off", beep, 0);
    wait_closed(len);
    check(len >= 10 && len <= 14, "R8 dwell resumes", len, 12);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_up_two();
    t_down_gaps();
    t_lowest();
    t_same_floor();
    t_overload();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule